// File: doc/BRIEF.md
# Clock Generator Configuration Register Slave (I2C)

This block is a two-wire serial slave that owns a small bank of byte-wide configuration registers for a clock generator. The bus lines are sampled by a fast system clock, passed through a two-stage synchroniser and a stability filter, and decoded into start, stop and clock-edge events. SDA is driven open-drain: the block only ever pulls it low, through an output-enable. SCL is an input only, because the slave never stretches the clock.

A write transfer addresses the slave, then sends two bytes that are acknowledged but ignored: a command code and a byte count. Every later byte is stored in order, starting at register 0. The master may end the write with a stop after any whole byte. Registers the write never reached keep their values, and bytes past the last register are acknowledged and dropped. A read transfer returns a byte count first, and then every register from register 0 upward.

The register contents drive the block's outputs all the time. A one-cycle strobe per register marks each update. All registers load fixed defaults at reset.

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: While reset is held and after it is released, cfg_o reads the defaults, register 0 in bits 7:0 up to register 6 in bits 55:48: 81h, 3Ch, A5h, 00h, 05h, EFh, 23h. sda_oe_o and cfg_wr_stb_o are 0.
- R2: The slave acknowledges only the address bytes D2h (write) and D3h (read), which are 7-bit address 69h with the R/W bit as bit 0. For any other address it leaves SDA released and ignores the bus until the next stop.
- R3: In a write, the first two bytes after the address are acknowledged and have no effect on any register. The data bytes that follow go to register 0, then register 1, and so on. Every byte is acknowledged.
- R4: A stop after any whole data byte ends the write. Registers not reached keep their previous contents, and cfg_o changes only in a cycle where a write strobe is set.
- R5: Data bytes after register 6 are acknowledged and discarded.
- R6: A byte is committed only when all 8 of its bits have arrived. A stop or repeated start partway through a byte discards that byte.
- R7: A read returns the count byte 07h, and then registers 0 to 6 in order, MSB first. Every byte after those reads as FFh.
- R8: When the master answers a read byte with NACK, the slave releases SDA and drives nothing more until a stop or start.
- R9: Each committed register write raises the matching bit of cfg_wr_stb_o for exactly one cycle, in the cycle cfg_o takes the new value. At most one strobe bit is set at a time.
- R10: sda_oe_o changes only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain), 0 releases it |
| cfg_o | output | 56 | Register bank, register k in bits 8k+7:8k |
| cfg_wr_stb_o | output | 7 | One-cycle strobe per register on update |

## Verification
A bus edge reaches the protocol engine after two synchroniser stages, the filter's stability count (3 cycles by default) and one cycle of edge detection. sda_oe_o changes in the cycle after that. A received byte reaches cfg_o and the strobe two cycles after its eighth SCL rise has been detected. The bench model holds each quarter of an SCL period for 20 system clocks, well beyond that pipeline. It reads acknowledge and read-data bits in the middle of the SCL high phase, and compares cfg_o and the strobe count only after the stop has been driven and a further quarter has passed. Every update is therefore settled when sampled, and every sample is taken one time step after a clock edge.

// File: rtl/clkcfg_pkg.sv
`timescale 1ns/1ps
// Package: shared protocol state type for the configuration slave.
// Assumes: nothing beyond standard SystemVerilog.
package clkcfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_WAIT_STOP
    } bus_state_t;

endpackage

// File: rtl/i2c_line_filter.sv
`timescale 1ns/1ps
// Module: i2c_line_filter
// Brings one bus line into the clk domain through two flip-flops. The
// output follows only after the synchronised value has differed from it
// for FILT_LEN consecutive cycles, which rejects short glitches.
// Assumes: the line idles high; FILT_LEN >= 1.
module i2c_line_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(FILT_LEN - 1);

    logic sync_a;
    logic sync_b;
    logic [CW-1:0] stable_cnt;

    // Two-stage synchroniser, reset to the idle-high level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a <= 1'b1;
            sync_b <= 1'b1;
        end else begin
            sync_a <= line_i;
            sync_b <= sync_a;
        end
    end

    // Count cycles of disagreement and take the new level once it has held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stable_cnt <= '0;
            line_o     <= 1'b1;
        end else if (sync_b == line_o) begin
            stable_cnt <= '0;
        end else if (stable_cnt == CNT_LAST) begin
            stable_cnt <= '0;
            line_o     <= sync_b;
        end else begin
            stable_cnt <= stable_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_bus_events.sv
`timescale 1ns/1ps
// Module: i2c_bus_events
// Turns the filtered SCL/SDA levels into one-cycle events: SCL rise, SCL
// fall, start (SDA falls with SCL high) and stop (SDA rises with SCL high).
// Assumes: inputs are already synchronous to clk.
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_d;
    logic sda_d;

    // Keep last-cycle levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_f;
            sda_d <= sda_f;
        end
    end

    // Decode edges and bus conditions from the level pairs.
    always_comb begin
        scl_rise  = scl_f & ~scl_d;
        scl_fall  = ~scl_f & scl_d;
        start_det = scl_f & scl_d & sda_d & ~sda_f;
        stop_det  = scl_f & scl_d & ~sda_d & sda_f;
    end
endmodule

// File: rtl/clkcfg_reg_bank.sv
`timescale 1ns/1ps
// Module: clkcfg_reg_bank
// NREG byte registers with reset defaults. A write request updates one
// register and raises its strobe in the same cycle the new value appears.
// Assumes: wr_idx < NREG whenever wr_en is set.
module clkcfg_reg_bank #(
    parameter int            NREG     = 7,
    parameter int            IDX_W    = 3,
    parameter logic [NREG*8-1:0] DEFAULTS = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [7:0]        wr_data,
    output logic [NREG*8-1:0] reg_flat,
    output logic [NREG-1:0]   wr_stb
);
    for (genvar k = 0; k < NREG; k++) begin : g_reg
        logic hit;
        assign hit = wr_en && (wr_idx == IDX_W'(k));

        // Hold register k, loading its default at reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                reg_flat[k*8 +: 8] <= DEFAULTS[k*8 +: 8];
                wr_stb[k]          <= 1'b0;
            end else begin
                wr_stb[k] <= hit;
                if (hit) begin
                    reg_flat[k*8 +: 8] <= wr_data;
                end
            end
        end
    end
endmodule

// File: rtl/clkcfg_i2c_fsm.sv
`timescale 1ns/1ps
// Module: clkcfg_i2c_fsm
// Protocol engine. Matches the address and acknowledges. On a write, it
// skips the command and count bytes and then issues one register write per
// whole data byte. On a read, it shifts out a count followed by the
// registers. A stop returns to idle and a start restarts the address phase.
// Assumes: events come from i2c_bus_events; SCL low lasts longer than one cycle.
module clkcfg_i2c_fsm
    import clkcfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         NREG     = 7,
    parameter int         IDX_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_f,
    input  logic [NREG*8-1:0] reg_flat,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [7:0]        wr_data
);
    localparam int               CNT_W    = $clog2(NREG + 3);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(NREG + 2);
    localparam logic [CNT_W-1:0] SKIP_N   = CNT_W'(2);
    localparam logic [7:0]       RD_COUNT = 8'(NREG);

    bus_state_t       state;
    logic [3:0]       bit_cnt;
    logic [7:0]       shreg;
    logic [CNT_W-1:0] byte_cnt;
    logic [CNT_W-1:0] byte_inc;
    logic [CNT_W-1:0] tx_idx;
    logic [CNT_W-1:0] data_slot;
    logic [7:0]       tx_byte;
    logic [7:0]       rx_byte;
    logic             rd_q;
    logic             commit_ok;

    // Saturating next byte index, data slot and commit window.
    always_comb begin
        byte_inc  = (byte_cnt == CNT_SAT) ? byte_cnt : byte_cnt + 1'b1;
        data_slot = byte_cnt - SKIP_N;
        commit_ok = (byte_cnt >= SKIP_N) && (byte_cnt < CNT_SAT);
        rx_byte   = {shreg[6:0], sda_f};
        tx_idx    = (state == ST_ADDR_ACK) ? '0 : byte_inc;
    end

    // Select the byte to transmit: count, registers, then idle-high filler.
    always_comb begin
        tx_byte = 8'hFF;
        if (tx_idx == '0) begin
            tx_byte = RD_COUNT;
        end
        for (int k = 0; k < NREG; k++) begin
            if (tx_idx == CNT_W'(k + 1)) begin
                tx_byte = reg_flat[k*8 +: 8];
            end
        end
    end

    // Protocol state machine, SDA drive and register write requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            byte_cnt <= '0;
            rd_q     <= 1'b0;
            sda_oe   <= 1'b0;
            wr_en    <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (start_det) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (scl_rise && bit_cnt < 4'd8) begin
                            shreg   <= rx_byte;
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            if (shreg[7:1] == DEV_ADDR) begin
                                state  <= ST_ADDR_ACK;
                                rd_q   <= shreg[0];
                                sda_oe <= 1'b1;
                            end else begin
                                state <= ST_WAIT_STOP;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bit_cnt  <= '0;
                            byte_cnt <= '0;
                            if (rd_q) begin
                                state  <= ST_RD_BYTE;
                                shreg  <= tx_byte;
                                sda_oe <= ~tx_byte[7];
                            end else begin
                                state  <= ST_WR_BYTE;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_WR_BYTE: begin
                        if (scl_rise && bit_cnt < 4'd8) begin
                            shreg   <= rx_byte;
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == 4'd7) begin
                                byte_cnt <= byte_inc;
                                if (commit_ok) begin
                                    wr_en   <= 1'b1;
                                    wr_idx  <= IDX_W'(data_slot);
                                    wr_data <= rx_byte;
                                end
                            end
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            state  <= ST_WR_ACK;
                            sda_oe <= 1'b1;
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) begin
                            state   <= ST_WR_BYTE;
                            bit_cnt <= '0;
                            sda_oe  <= 1'b0;
                        end
                    end
                    ST_RD_BYTE: begin
                        if (scl_fall) begin
                            if (bit_cnt == 4'd7) begin
                                state   <= ST_RD_ACK;
                                bit_cnt <= '0;
                                sda_oe  <= 1'b0;
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                                shreg   <= {shreg[6:0], 1'b1};
                                sda_oe  <= ~shreg[6];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise && sda_f) begin
                            state <= ST_WAIT_STOP;
                        end else if (scl_fall) begin
                            state    <= ST_RD_BYTE;
                            byte_cnt <= byte_inc;
                            bit_cnt  <= '0;
                            shreg    <= tx_byte;
                            sda_oe   <= ~tx_byte[7];
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/clkcfg_i2c_slave.sv
`timescale 1ns/1ps
// Module: clkcfg_i2c_slave (top)
// Two-wire configuration slave for a clock generator: line filters, bus
// event decoder, protocol engine and register bank.
// Assumes: standard-mode bus timing, far slower than clk; SDA open-drain
// with an external pull-up; no clock stretching; 7-bit addressing only.
module clkcfg_i2c_slave #(
    parameter logic [6:0]        DEV_ADDR = 7'h69,
    parameter int                NREG     = 7,
    parameter int                FILT_LEN = 3,
    parameter logic [NREG*8-1:0] DEFAULTS = 56'h23EF_0500_A53C_81
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    output logic [NREG*8-1:0] cfg_o,
    output logic [NREG-1:0]   cfg_wr_stb_o
);
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

    logic [1:0]       raw_lines;
    logic [1:0]       filt_lines;
    logic             scl_filt;
    logic             sda_filt;
    logic             scl_rise;
    logic             scl_fall;
    logic             start_det;
    logic             stop_det;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0]       wr_data;

    assign raw_lines = {sda_i, scl_i};
    assign scl_filt  = filt_lines[0];
    assign sda_filt  = filt_lines[1];

    for (genvar l = 0; l < 2; l++) begin : g_line
        i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[l]),
            .line_o (filt_lines[l])
        );
    end

    i2c_bus_events u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_f     (scl_filt),
        .sda_f     (sda_filt),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    clkcfg_i2c_fsm #(
        .DEV_ADDR (DEV_ADDR),
        .NREG     (NREG),
        .IDX_W    (IDX_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_f     (sda_filt),
        .reg_flat  (cfg_o),
        .sda_oe    (sda_oe_o),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data)
    );

    clkcfg_reg_bank #(
        .NREG     (NREG),
        .IDX_W    (IDX_W),
        .DEFAULTS (DEFAULTS)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .reg_flat (cfg_o),
        .wr_stb   (cfg_wr_stb_o)
    );
endmodule

// File: rtl/clkcfg_i2c_slave_chk.sv
`timescale 1ns/1ps
// Module: clkcfg_i2c_slave_chk
// Property checker bound to the top: reset state, strobe shape, register
// stability and SDA drive timing.
// Assumes: bound with the top's parameters.
module clkcfg_i2c_slave_chk #(
    parameter int NREG = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_f,
    input logic              sda_oe,
    input logic [NREG*8-1:0] cfg,
    input logic [NREG-1:0]   stb
);
    // R1: one cycle after a reset cycle, SDA is released and no strobe is set.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!sda_oe && stb == '0));

    // R9: strobes are one-hot or idle.
    p_strobe_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stb));

    // R9: a strobe lasts a single cycle.
    p_strobe_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stb != '0) |=> (stb == '0));

    // R4: register outputs move only together with a strobe.
    p_cfg_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg) |-> (stb != '0));

    // R10: SDA drive changes only while the filtered SCL is low.
    p_sda_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_f);
endmodule

bind clkcfg_i2c_slave clkcfg_i2c_slave_chk #(.NREG(NREG)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_f  (scl_filt),
    .sda_oe (sda_oe_o),
    .cfg    (cfg_o),
    .stb    (cfg_wr_stb_o)
);

// File: tb/clkcfg_i2c_slave_tb_top.sv
`timescale 1ns/1ps
// Bench: drives the bus as a master with a bench-side register model.
module clkcfg_i2c_slave_tb_top;
    localparam int NREG = 7;
    localparam int Q    = 20;
    localparam int WD   = 190000;
    localparam logic [55:0] DEFV = 56'h23EF_0500_A53C_81;
    localparam int NVEC = 4;
    localparam int VEC_LEN [NVEC] = '{3, 7, 9, 1};
    localparam logic [7:0] VEC_DATA [NVEC][9] = '{
        '{8'h12, 8'h34, 8'h56, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
        '{8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'hE5, 8'hF6, 8'h07, 8'h00, 8'h00},
        '{8'h5A, 8'h6B, 8'h7C, 8'h8D, 8'h9E, 8'hAF, 8'h10, 8'hEE, 8'hDD},
        '{8'h99, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_bus;
    logic sda_oe;
    logic [55:0] cfg;
    logic [6:0] stb;
    int n_chk = 0;
    int n_fail = 0;
    int stb_cnt = 0;
    logic [7:0] model [NREG];

    always #4 clk = ~clk;
    assign sda_bus = m_sda & ~sda_oe;

    clkcfg_i2c_slave dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (m_scl),
        .sda_i        (sda_bus),
        .sda_oe_o     (sda_oe),
        .cfg_o        (cfg),
        .cfg_wr_stb_o (stb)
    );

    // Count strobe pulses seen at the port.
    always @(posedge clk) if (rst_n) stb_cnt <= stb_cnt + $countones(stb);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(2 * Q);
    endtask

    task automatic clock_bit(input bit b, output bit s);
        m_sda = b; tick(Q); m_scl = 1'b1; tick(Q);
        s = sda_bus; tick(Q); m_scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        bit s;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
        clock_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic recv_byte(input bit ack_in, output logic [7:0] b);
        bit s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            b[i] = s;
        end
        clock_bit(!ack_in, s);
    endtask

    function automatic logic [55:0] model_flat();
        logic [55:0] f;
        for (int i = 0; i < NREG; i++) f[i*8 +: 8] = model[i];
        return f;
    endfunction

    // R7: read count and all registers, comparing with the model.
    task automatic read_all(input string tag);
        bit ack;
        logic [7:0] b;
        bus_start();
        send_byte(8'hD3, ack);
        chk(ack, "R2 read address ack", 64'(ack), 1);
        recv_byte(1'b1, b);
        chk(b == 8'h07, "R7 count byte", 64'(b), 64'h07);
        for (int i = 0; i < NREG; i++) begin
            recv_byte(i != NREG - 1, b);
            chk(b == model[i], {"R7 readback ", tag}, 64'(b), 64'(model[i]));
        end
        bus_stop();
    endtask

    initial begin
        tick(WD);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit ack;
        bit s;
        int exp_stb;
        logic [7:0] b;
        for (int i = 0; i < NREG; i++) model[i] = DEFV[i*8 +: 8];
        tick(5);
        // R1: reset state while reset is held.
        chk(cfg == DEFV, "R1 defaults in reset", 64'(cfg), 64'(DEFV));
        chk(!sda_oe && stb == '0, "R1 outputs idle", 64'({sda_oe, stb}), 0);
        rst_n = 1'b1;
        tick(Q);
        chk(cfg == DEFV, "R1 defaults after reset", 64'(cfg), 64'(DEFV));

        // R3 R4 R5 R9: table of block writes, each followed by readback.
        for (int v = 0; v < NVEC; v++) begin
            exp_stb = stb_cnt + ((VEC_LEN[v] < NREG) ? VEC_LEN[v] : NREG);
            bus_start();
            send_byte(8'hD2, ack);
            chk(ack, "R2 write address ack", 64'(ack), 1);
            send_byte(8'h03, ack);
            chk(ack, "R3 command byte ack", 64'(ack), 1);
            send_byte(8'h41, ack);
            chk(ack, "R3 count byte ack", 64'(ack), 1);
            for (int j = 0; j < VEC_LEN[v]; j++) begin
                send_byte(VEC_DATA[v][j], ack);
                chk(ack, "R5 data byte ack", 64'(ack), 1);
                if (j < NREG) model[j] = VEC_DATA[v][j];
            end
            bus_stop();
            chk(cfg == model_flat(), "R4 register outputs after write", 64'(cfg), 64'(model_flat()));
            chk(stb_cnt == exp_stb, "R9 strobe count", 64'(stb_cnt), 64'(exp_stb));
            read_all("after table write");
        end

        // R2: a foreign address is not acknowledged and writes nothing.
        bus_start();
        send_byte(8'hA2, ack);
        chk(!ack, "R2 foreign address nack", 64'(ack), 0);
        send_byte(8'h00, ack);
        send_byte(8'h00, ack);
        send_byte(8'h77, ack);
        chk(!ack, "R2 bus ignored", 64'(ack), 0);
        bus_stop();
        chk(cfg == model_flat(), "R2 registers unchanged", 64'(cfg), 64'(model_flat()));

        // R6: stop in the middle of the second data byte.
        bus_start();
        send_byte(8'hD2, ack);
        send_byte(8'h00, ack);
        send_byte(8'h00, ack);
        send_byte(8'h3E, ack);
        model[0] = 8'h3E;
        for (int i = 0; i < 4; i++) clock_bit(1'b0, s);
        bus_stop();
        chk(cfg == model_flat(), "R6 partial byte at stop dropped", 64'(cfg), 64'(model_flat()));

        // R6: repeated start mid-byte, then read in the same transfer.
        bus_start();
        send_byte(8'hD2, ack);
        send_byte(8'h00, ack);
        send_byte(8'h00, ack);
        for (int i = 0; i < 5; i++) clock_bit(1'b0, s);
        bus_start();
        send_byte(8'hD3, ack);
        chk(ack, "R6 read after repeated start ack", 64'(ack), 1);
        recv_byte(1'b1, b);
        recv_byte(1'b0, b);
        chk(b == model[0], "R6 register 0 kept after repeated start", 64'(b), 64'(model[0]));
        // R8: after the NACK the slave must not drive further bits.
        for (int i = 0; i < 8; i++) begin
            clock_bit(1'b1, s);
            chk(s == 1'b1 && !sda_oe, "R8 released after nack", 64'(s), 1);
        end
        bus_stop();

        // R7: past the last register the read yields filler bytes.
        bus_start();
        send_byte(8'hD3, ack);
        for (int i = 0; i <= NREG; i++) recv_byte(1'b1, b);
        recv_byte(1'b0, b);
        chk(b == 8'hFF, "R7 byte past last register", 64'(b), 64'hFF);
        bus_stop();
        chk(cfg == model_flat(), "R4 registers intact after reads", 64'(cfg), 64'(model_flat()));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule